// File: doc/BRIEF.md
# Indexed Configuration Register Port

This block is a small configuration register bank that a host reaches through two adjacent byte-wide I/O ports. To reach a register, the host first writes its number to the index port. It then makes exactly one read or one write on the data port. Each pair of accesses touches one register. After the data access the index is spent, and the host must write a new one.

The bank has two registers:

- **Control register.** It is always reachable. One of its bits is the map-enable bit.
- **General configuration register.** It is reachable only while the map-enable bit is set. Its two low bits drive the top two bits of a 32-bit memory-mapped base address output. The low thirty bits of that output are always zero.

Firmware typically sets the map-enable bit, reads or updates the general register, and then clears the map-enable bit again.

Reads return data combinationally while the read strobe is high. Index and register updates take effect at the clock edge that ends the access.

Top module: `cfg_index_port`

## Requirements
- R1: A write to I/O address 0x22 (the index port) stores the written byte as the selected register number. Accesses to the registers go through I/O address 0x23 (the data port).
- R2: The control register, register number 0xC3, can be read and written through the data port whether map-enable is set or clear. Its reset value is 0x00.
- R3: Map-enable is bit 4 of the control register. While it is set, the general configuration register (register number 0xB8) can be read and written through the data port.
- R4: While map-enable is clear, a data-port write to register 0xB8 leaves it unchanged, and a data-port read of register 0xB8 returns 0xFF.
- R5: After map-enable has been set and then cleared, register 0xB8 is gated again exactly as in R4.
- R6: One data-port access, read or write, uses up the index. A further data-port access before a new index write reads 0xFF, and a write in that position changes nothing.
- R7: With an index that names neither 0xC3 nor 0xB8, a data-port read returns 0xFF. A data-port write is dropped, leaving both registers unchanged.
- R8: base_addr equals {general[1:0], 30'b0}. It changes at the clock edge that completes a write to register 0xB8.
- R9: After reset, map-enable is clear, the general register is 0x00, no index is held, and base_addr is 0.
- R10: io_rdata is 0xFF whenever the data port is not being read, including during reads of the index port.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 8 | I/O address of the current access |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, valid while io_rd is high |
| base_addr | output | 32 | Memory-mapped base address |

## Verification
The assertions assume the following about the host:

- It never raises io_wr and io_rd in the same cycle.
- Every strobe lasts exactly one cycle.

The bench stimulus respects both assumptions. It drives at most one strobe per step from its vector table, and it holds both strobes low between steps. The gating and consumption properties therefore only ever see accesses that are cleanly separated.

// File: rtl/cfg_index_port.sv
module cfg_index_port #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int BASE_W = 32,
  parameter logic [ADDR_W-1:0] IDX_PORT = 8'h22,
  parameter logic [ADDR_W-1:0] DAT_PORT = 8'h23,
  parameter logic [DATA_W-1:0] CTL_IDX  = 8'hC3,
  parameter logic [DATA_W-1:0] GEN_IDX  = 8'hB8,
  parameter int MAP_BIT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [DATA_W-1:0] io_wdata,
  output logic [DATA_W-1:0] io_rdata,
  output logic [BASE_W-1:0] base_addr
);
  localparam int HI_W = 2;

  logic [DATA_W-1:0] idx_q, ctl_q, gen_q;
  logic              idx_vld;

  wire idx_wr  = io_wr & (io_addr == IDX_PORT);
  wire dat_wr  = io_wr & (io_addr == DAT_PORT);
  wire dat_rd  = io_rd & (io_addr == DAT_PORT);
  wire map_en  = ctl_q[MAP_BIT];
  wire hit_ctl = idx_vld & (idx_q == CTL_IDX);
  wire hit_gen = idx_vld & (idx_q == GEN_IDX) & map_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q   <= '0;
      idx_vld <= 1'b0;
      ctl_q   <= '0;
      gen_q   <= '0;
    end else begin
      if (idx_wr) begin
        idx_q   <= io_wdata;
        idx_vld <= 1'b1;
      end else if (dat_wr | dat_rd) begin
        idx_vld <= 1'b0;
      end
      if (dat_wr & hit_ctl) ctl_q <= io_wdata;
      if (dat_wr & hit_gen) gen_q <= io_wdata;
    end
  end

  always_comb begin
    io_rdata = '1;
    if (dat_rd) begin
      if (hit_ctl)      io_rdata = ctl_q;
      else if (hit_gen) io_rdata = gen_q;
    end
  end

  assign base_addr = {gen_q[HI_W-1:0], {(BASE_W-HI_W){1'b0}}};

  // Control register write lands regardless of map-enable
  assert_ctl_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && idx_vld && idx_q == CTL_IDX) |=> ctl_q == $past(io_wdata));

  assert_gated_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && !map_en) |=> $stable(gen_q));

  assert_index_spent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr || dat_rd) ##1 dat_rd |-> io_rdata == '1);

  assert_unmapped_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && idx_vld && idx_q != CTL_IDX && idx_q != GEN_IDX)
      |=> ($stable(ctl_q) && $stable(gen_q)));

  assert_base_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(dat_wr && hit_gen) |=> $stable(base_addr));
endmodule

// File: tb/cfg_index_port_tb.sv
module cfg_index_port_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 36;
  localparam logic [1:0] OI = 2'd0, OW = 2'd1, OR = 2'd2;
  // vector: {req[3:0], op[1:0], addr[7:0], data[7:0], exp_rdata[7:0], exp_base_hi[1:0]}
  localparam logic [31:0] VEC [NV] = '{
    {4'd9,  OR, 8'h23, 8'h00, 8'hFF, 2'd0},  // R9 no index held
    {4'd1,  OW, 8'h22, 8'hB8, 8'hFF, 2'd0},  // R1
    {4'd4,  OR, 8'h23, 8'h00, 8'hFF, 2'd0},  // R4 gated read
    {4'd1,  OW, 8'h22, 8'hB8, 8'hFF, 2'd0},
    {4'd4,  OW, 8'h23, 8'h03, 8'hFF, 2'd0},  // R4 gated write dropped
    {4'd1,  OW, 8'h22, 8'hC3, 8'hFF, 2'd0},
    {4'd2,  OR, 8'h23, 8'h00, 8'h00, 2'd0},  // R2 ctl reads with map clear
    {4'd1,  OW, 8'h22, 8'hC3, 8'hFF, 2'd0},
    {4'd2,  OW, 8'h23, 8'h10, 8'hFF, 2'd0},  // R2 set map-enable
    {4'd1,  OW, 8'h22, 8'hC3, 8'hFF, 2'd0},
    {4'd2,  OR, 8'h23, 8'h00, 8'h10, 2'd0},  // R2
    {4'd1,  OW, 8'h22, 8'hB8, 8'hFF, 2'd0},
    {4'd8,  OW, 8'h23, 8'h02, 8'hFF, 2'd2},  // R8 R3 gen write -> base
    {4'd1,  OW, 8'h22, 8'hB8, 8'hFF, 2'd2},
    {4'd3,  OR, 8'h23, 8'h00, 8'h02, 2'd2},  // R3 gen readable
    {4'd6,  OR, 8'h23, 8'h00, 8'hFF, 2'd2},  // R6 index spent
    {4'd6,  OW, 8'h23, 8'h03, 8'hFF, 2'd2},  // R6 write dropped
    {4'd1,  OW, 8'h22, 8'hB8, 8'hFF, 2'd2},
    {4'd6,  OR, 8'h23, 8'h00, 8'h02, 2'd2},  // R6 gen unchanged
    {4'd1,  OW, 8'h22, 8'h55, 8'hFF, 2'd2},
    {4'd7,  OW, 8'h23, 8'hAA, 8'hFF, 2'd2},  // R7 dropped
    {4'd1,  OW, 8'h22, 8'h55, 8'hFF, 2'd2},
    {4'd7,  OR, 8'h23, 8'h00, 8'hFF, 2'd2},  // R7 reads FF
    {4'd1,  OW, 8'h22, 8'hC3, 8'hFF, 2'd2},
    {4'd7,  OR, 8'h23, 8'h00, 8'h10, 2'd2},  // R7 ctl untouched
    {4'd1,  OW, 8'h22, 8'hC3, 8'hFF, 2'd2},
    {4'd5,  OW, 8'h23, 8'h00, 8'hFF, 2'd2},  // R5 clear map-enable
    {4'd1,  OW, 8'h22, 8'hB8, 8'hFF, 2'd2},
    {4'd5,  OR, 8'h23, 8'h00, 8'hFF, 2'd2},  // R5 gated again
    {4'd1,  OW, 8'h22, 8'hB8, 8'hFF, 2'd2},
    {4'd5,  OW, 8'h23, 8'h01, 8'hFF, 2'd2},  // R5 write dropped
    {4'd10, OR, 8'h22, 8'h00, 8'hFF, 2'd2},  // R10 index port read
    {4'd10, OI, 8'h23, 8'h00, 8'hFF, 2'd2},  // R10 idle
    {4'd1,  OW, 8'h22, 8'hC3, 8'hFF, 2'd2},
    {4'd3,  OW, 8'h23, 8'h10, 8'hFF, 2'd2},  // R3 re-enable
    {4'd1,  OW, 8'h22, 8'hB8, 8'hFF, 2'd2}
  };

  logic clk = 1'b0, rst_n = 1'b0, io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0] io_addr = '0, io_wdata = '0;
  logic [7:0] io_rdata;
  logic [31:0] base_addr;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  cfg_index_port u_dut (.clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
    .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata), .base_addr(base_addr));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input int req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic [1:0] op, input logic [7:0] a, input logic [7:0] d,
                        input int req, input logic [7:0] er, input logic [1:0] eb);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = (op == OW); io_rd = (op == OR);
    #1;
    if (op != OW) chk(req, {24'd0, io_rdata}, {24'd0, er});
    @(posedge clk); #1;
    io_wr = 1'b0; io_rd = 1'b0;
    chk(req, base_addr, {eb, 30'd0});
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(9, base_addr, 32'd0);                   // R9 reset base
    chk(9, {24'd0, io_rdata}, 32'h0000_00FF);   // R10 idle output
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < NV; i++)
      access(VEC[i][27:26], VEC[i][25:18], VEC[i][17:10], int'(VEC[i][31:28]),
             VEC[i][9:2], VEC[i][1:0]);
    // R8 both base bits
    access(OW, 8'h23, 8'h03, 8, 8'hFF, 2'd3);
    access(OW, 8'h22, 8'hB8, 8, 8'hFF, 2'd3);
    access(OW, 8'h23, 8'h01, 8, 8'hFF, 2'd1);
    // R9 reset in the middle of a sequence
    access(OW, 8'h22, 8'hC3, 9, 8'hFF, 2'd1);
    @(negedge clk); rst_n = 1'b0;
    @(posedge clk); #1;
    chk(9, base_addr, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    access(OR, 8'h23, 8'h00, 9, 8'hFF, 2'd0);   // R9 index cleared
    access(OW, 8'h22, 8'hC3, 9, 8'hFF, 2'd0);
    access(OR, 8'h23, 8'h00, 9, 8'h00, 2'd0);   // R9 map-enable clear
    access(OW, 8'h22, 8'hB8, 9, 8'hFF, 2'd0);
    access(OR, 8'h23, 8'h00, 9, 8'hFF, 2'd0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule